// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual address into a 30-bit physical address within the same cycle. It holds 32 mapping slots. Every slot is compared against the page number at once, and a mapping may live in any slot. Pages are 4 KB, so the low 12 address bits pass through unchanged. Addresses whose two top bits are both set skip translation and map straight onto physical space. A mapped access that finds no slot, that hits a slot marked not valid, or that stores through a read-only slot raises exactly one fault. The fault records the faulting page and the full address, so the handler can insert a mapping quickly.

Software manages the contents through four registers: a slot pointer, a staged key, a staged value and the last faulting address. It also uses four commands: search by key, write at a pseudo-random slot, read by pointer and write by pointer. The random slot comes from a free-running down-counter that never reaches the four lowest slots, so those slots can hold pinned mappings. Every command is privileged. When one is issued in user mode it is dropped and a privilege fault is flagged instead.

Top module: `vmap_tlb`

## Requirements
- R1: For an address with bits 31:30 not both 1, a slot whose stored key equals bits 31:12 hits. `xl_paddr` then equals {stored 18-bit frame, address bits 11:0}, combinationally in the same cycle. When no slot hits, the frame part is zero.
- R2: For an address with bits 31:30 equal to 2'b11, `xl_paddr` is address bits 29:0 and no fault is raised.
- R3: A requested mapped address that hits no slot raises `xl_miss`. A stored key whose top two bits are 2'b11 never hits, for a lookup or for a search.
- R4: On any of `xl_miss`, `xl_invalid` or `xl_wprot`, the key register becomes {address bits 31:12, 12'h000} and the fault-address register becomes the full address, from the next cycle. This capture overrides a command or register write in the same cycle.
- R5: Value bit 0 is the valid flag and bit 1 is the write-permit flag. A hit on a slot with valid clear raises `xl_invalid`. A store hitting a valid slot with write-permit clear raises `xl_wprot`. At most one fault is raised per cycle.
- R6: The random counter resets to 31, steps down by one on every clock, and wraps from 4 to 31. Command 2'b01 writes the staged key and value into the slot it currently names, so slots 0 to 3 are never written by it.
- R7: Command 2'b11 writes the staged key and value into the slot named by pointer bits 4:0.
- R8: Command 2'b10 loads the key and value registers from the slot named by pointer bits 4:0, visible from the next cycle.
- R9: Command 2'b00 sets the pointer register to the index of the slot whose key equals the staged key. If no slot matches, the pointer register becomes 32'h8000_0000.
- R10: A command with `cmd_user` high changes no register and no slot, and `cmd_priv_fault` is high in that cycle.
- R11: Register writes use select 0 for the pointer (bits 31 and 4:0 kept), 1 for the key (bits 31:12 kept), 2 for the value (bits 29:12 and 1:0 kept) and 3 for the fault address (all bits kept). Bits that are not kept read back as zero.
- R12: After reset all four registers read zero and every slot holds a key with top bits 2'b11, so nothing hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_req | input | 1 | Translation request this cycle |
| xl_vaddr | input | 32 | Virtual address |
| xl_store | input | 1 | Request is a store |
| xl_paddr | output | 30 | Physical address |
| xl_miss | output | 1 | No slot matched |
| xl_invalid | output | 1 | Matched slot not valid |
| xl_wprot | output | 1 | Store to read-only slot |
| cmd_valid | input | 1 | Management command this cycle |
| cmd_op | input | 2 | 0 search, 1 write random, 2 read by pointer, 3 write by pointer |
| cmd_user | input | 1 | Issuer is in user mode |
| cmd_priv_fault | output | 1 | Command refused for privilege |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| index_o | output | 32 | Pointer register |
| entry_hi_o | output | 32 | Staged key register |
| entry_lo_o | output | 32 | Staged value register |
| bad_addr_o | output | 32 | Last faulting address |

## Verification
Slot contents can only be seen through translations and read commands. A corrupted key or frame therefore stays hidden until that slot is looked up. It then shows in the same cycle as a wrong `xl_paddr` or a false miss. A wrong random-counter phase shows when a later lookup or read-back finds a mapping in an unexpected slot. A capture or search error shows in the register outputs one cycle after the event. For this reason the bench compares all outputs against its model on every cycle and reads back every slot it has touched.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 30;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PFN_W  = PA_W - PAGE_W;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             wr_ok;
    logic             valid;
  } tlb_val_t;

  typedef enum logic [1:0] {
    CMD_SEARCH = 2'd0,
    CMD_WRRAND = 2'd1,
    CMD_RDIDX  = 2'd2,
    CMD_WRIDX  = 2'd3
  } tlb_cmd_e;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_HI    = 2'd1,
    SEL_LO    = 2'd2,
    SEL_BAD   = 2'd3
  } tlb_sel_e;
endpackage

// File: rtl/tlb_entry.sv
`timescale 1ns/1ps
module tlb_entry
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  tlb_val_t         wr_val,
  input  logic [VPN_W-1:0] xl_vpn,
  input  logic [VPN_W-1:0] srch_vpn,
  output logic [VPN_W-1:0] vpn_o,
  output tlb_val_t         val_o,
  output logic             xl_hit_o,
  output logic             srch_hit_o
);
  localparam logic [VPN_W-1:0] DEAD_KEY = {2'b11, {(VPN_W-2){1'b0}}};

  logic [VPN_W-1:0] vpn_q, vpn_d;
  tlb_val_t         val_q, val_d;
  logic             live;

  always_comb begin
    vpn_d = vpn_q;
    val_d = val_q;
    if (wr_en) begin
      vpn_d = wr_vpn;
      val_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q <= DEAD_KEY;
      val_q <= '0;
    end else if (wr_en) begin
      vpn_q <= vpn_d;
      val_q <= val_d;
    end
  end

  assign live       = (vpn_q[VPN_W-1 -: 2] != 2'b11);
  assign xl_hit_o   = live && (vpn_q == xl_vpn);
  assign srch_hit_o = live && (vpn_q == srch_vpn);
  assign vpn_o      = vpn_q;
  assign val_o      = val_q;

  AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vpn_o == $past(wr_vpn)) && (val_o == $past(wr_val))); // R7
endmodule

// File: rtl/tlb_victim_ctr.sv
`timescale 1ns/1ps
module tlb_victim_ctr #(
  parameter int ENTRIES  = 32,
  parameter int RESERVED = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [$clog2(ENTRIES)-1:0] victim_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] TOP   = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] FLOOR = IDX_W'(RESERVED);

  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == FLOOR) cnt_d = TOP;
    else                cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TOP;
    else        cnt_q <= cnt_d;
  end

  assign victim_o = cnt_q;

  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_o >= FLOOR); // R6
  AST_VICTIM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_o == FLOOR) |=> (victim_o == TOP)); // R6
  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_o != FLOOR) |=> (victim_o == $past(victim_o) - 1'b1)); // R6
endmodule

// File: rtl/tlb_regs.sv
`timescale 1ns/1ps
module tlb_regs
  import tlb_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_cap,
  input  logic [VA_W-1:0]  fault_va,
  input  logic             cmd_fire,
  input  tlb_cmd_e         cmd_op,
  input  logic             srch_hit,
  input  logic [IDX_W-1:0] srch_idx,
  input  logic [VPN_W-1:0] rd_vpn,
  input  tlb_val_t         rd_val,
  input  logic             reg_we,
  input  tlb_sel_e         reg_sel,
  input  logic [VA_W-1:0]  reg_wdata,
  output logic [IDX_W-1:0] idx_o,
  output logic [VPN_W-1:0] hi_vpn_o,
  output tlb_val_t         lo_val_o,
  output logic [VA_W-1:0]  index_o,
  output logic [VA_W-1:0]  entry_hi_o,
  output logic [VA_W-1:0]  entry_lo_o,
  output logic [VA_W-1:0]  bad_addr_o
);
  logic             nf_q, nf_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VPN_W-1:0] hi_q, hi_d;
  tlb_val_t         lo_q, lo_d;
  logic [VA_W-1:0]  bad_q, bad_d;
  logic             unused_wdata;

  always_comb begin
    nf_d  = nf_q;
    idx_d = idx_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    bad_d = bad_q;
    if (reg_we) begin
      unique case (reg_sel)
        SEL_INDEX: begin
          nf_d  = reg_wdata[VA_W-1];
          idx_d = reg_wdata[IDX_W-1:0];
        end
        SEL_HI:  hi_d  = reg_wdata[VA_W-1:PAGE_W];
        SEL_LO:  lo_d  = '{pfn: reg_wdata[PA_W-1:PAGE_W], wr_ok: reg_wdata[1], valid: reg_wdata[0]};
        default: bad_d = reg_wdata;
      endcase
    end
    if (cmd_fire) begin
      unique case (cmd_op)
        CMD_SEARCH: begin
          nf_d  = !srch_hit;
          idx_d = srch_hit ? srch_idx : '0;
        end
        CMD_RDIDX: begin
          hi_d = rd_vpn;
          lo_d = rd_val;
        end
        default: ;
      endcase
    end
    if (fault_cap) begin
      hi_d  = fault_va[VA_W-1:PAGE_W];
      bad_d = fault_va;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_q  <= 1'b0;
      idx_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      bad_q <= '0;
    end else begin
      nf_q  <= nf_d;
      idx_q <= idx_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      bad_q <= bad_d;
    end
  end

  assign unused_wdata = ^reg_wdata;
  assign idx_o        = idx_q;
  assign hi_vpn_o     = hi_q;
  assign lo_val_o     = lo_q;
  assign index_o      = {nf_q, {(VA_W-1-IDX_W){1'b0}}, idx_q};
  assign entry_hi_o   = {hi_q, {PAGE_W{1'b0}}};
  assign entry_lo_o   = {{(VA_W-PA_W){1'b0}}, lo_q.pfn, {(PAGE_W-2){1'b0}}, lo_q.wr_ok, lo_q.valid};
  assign bad_addr_o   = bad_q;

  AST_SEARCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == CMD_SEARCH && !srch_hit && !reg_we) |=> index_o == 32'h8000_0000); // R9
  AST_SEARCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_op == CMD_SEARCH && srch_hit) |=> !index_o[VA_W-1]); // R9
endmodule

// File: rtl/vmap_tlb.sv
`timescale 1ns/1ps
module vmap_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int RESERVED = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xl_req,
  input  logic [31:0] xl_vaddr,
  input  logic        xl_store,
  output logic [29:0] xl_paddr,
  output logic        xl_miss,
  output logic        xl_invalid,
  output logic        xl_wprot,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic        cmd_user,
  output logic        cmd_priv_fault,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] index_o,
  output logic [31:0] entry_hi_o,
  output logic [31:0] entry_lo_o,
  output logic [31:0] bad_addr_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlb_cmd_e         cmd_e;
  logic             cmd_fire;
  logic [IDX_W-1:0] victim, idx;
  logic [VPN_W-1:0] hi_vpn;
  tlb_val_t         lo_val;

  logic [ENTRIES-1:0] wr_en, xl_hit, srch_hit;
  logic [VPN_W-1:0]   vpn_arr [ENTRIES];
  tlb_val_t           val_arr [ENTRIES];

  logic             unmapped, hit_any, srch_any, fault;
  tlb_val_t         hit_val;
  logic [IDX_W-1:0] srch_idx;

  assign cmd_e          = tlb_cmd_e'(cmd_op);
  assign cmd_fire       = cmd_valid && !cmd_user;
  assign cmd_priv_fault = cmd_valid && cmd_user;

  tlb_victim_ctr #(.ENTRIES(ENTRIES), .RESERVED(RESERVED)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .victim_o (victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign wr_en[g] = cmd_fire &&
                      ((cmd_e == CMD_WRIDX  && idx    == IDX_W'(g)) ||
                       (cmd_e == CMD_WRRAND && victim == IDX_W'(g)));
    tlb_entry u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en[g]),
      .wr_vpn     (hi_vpn),
      .wr_val     (lo_val),
      .xl_vpn     (xl_vaddr[VA_W-1:PAGE_W]),
      .srch_vpn   (hi_vpn),
      .vpn_o      (vpn_arr[g]),
      .val_o      (val_arr[g]),
      .xl_hit_o   (xl_hit[g]),
      .srch_hit_o (srch_hit[g])
    );
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_val  = '0;
    srch_any = 1'b0;
    srch_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (xl_hit[i]) begin
        hit_any = 1'b1;
        hit_val = hit_val | val_arr[i];
      end
      if (srch_hit[i]) begin
        srch_any = 1'b1;
        srch_idx = srch_idx | IDX_W'(i);
      end
    end
  end

  assign unmapped   = &xl_vaddr[VA_W-1 -: 2];
  assign xl_paddr   = unmapped ? xl_vaddr[PA_W-1:0] : {hit_val.pfn, xl_vaddr[PAGE_W-1:0]};
  assign xl_miss    = xl_req && !unmapped && !hit_any;
  assign xl_invalid = xl_req && !unmapped && hit_any && !hit_val.valid;
  assign xl_wprot   = xl_req && !unmapped && hit_any && hit_val.valid && xl_store && !hit_val.wr_ok;
  assign fault      = xl_miss || xl_invalid || xl_wprot;

  tlb_regs #(.IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_cap  (fault),
    .fault_va   (xl_vaddr),
    .cmd_fire   (cmd_fire),
    .cmd_op     (cmd_e),
    .srch_hit   (srch_any),
    .srch_idx   (srch_idx),
    .rd_vpn     (vpn_arr[idx]),
    .rd_val     (val_arr[idx]),
    .reg_we     (reg_we),
    .reg_sel    (tlb_sel_e'(reg_sel)),
    .reg_wdata  (reg_wdata),
    .idx_o      (idx),
    .hi_vpn_o   (hi_vpn),
    .lo_val_o   (lo_val),
    .index_o    (index_o),
    .entry_hi_o (entry_hi_o),
    .entry_lo_o (entry_lo_o),
    .bad_addr_o (bad_addr_o)
  );

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xl_miss, xl_invalid, xl_wprot})); // R5
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && xl_vaddr[31:30] == 2'b11) |-> !(xl_miss || xl_invalid || xl_wprot)); // R2
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (bad_addr_o == $past(xl_vaddr)) && (entry_hi_o[31:12] == $past(xl_vaddr[31:12]))); // R4
  AST_PRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_user && !reg_we && !fault) |=>
      $stable(index_o) && $stable(entry_hi_o) && $stable(entry_lo_o)); // R10
  AST_RANDOM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_e == CMD_WRRAND) |-> (wr_en[RESERVED-1:0] == '0)); // R6
endmodule

// File: tb/test_vmap_tlb.sv
`timescale 1ns/1ps
module test_vmap_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_req = 1'b0, xl_store = 1'b0;
  logic [31:0] xl_vaddr = '0;
  logic [29:0] xl_paddr;
  logic        xl_miss, xl_invalid, xl_wprot;
  logic        cmd_valid = 1'b0, cmd_user = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic        cmd_priv_fault;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] index_o, entry_hi_o, entry_lo_o, bad_addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  string phase = "R12";

  // behavioural model state
  logic [19:0] m_key [32];
  logic [17:0] m_pfn [32];
  logic [1:0]  m_fl  [32];
  int          m_ctr;
  logic [31:0] m_index, m_hi, m_lo, m_bad;

  always #2.5 clk = ~clk;

  vmap_tlb i_vmap_tlb (
    .clk(clk), .rst_n(rst_n),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_store(xl_store),
    .xl_paddr(xl_paddr), .xl_miss(xl_miss), .xl_invalid(xl_invalid), .xl_wprot(xl_wprot),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_user(cmd_user), .cmd_priv_fault(cmd_priv_fault),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .index_o(index_o), .entry_hi_o(entry_hi_o), .entry_lo_o(entry_lo_o), .bad_addr_o(bad_addr_o)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%h expected=%h", what, phase, act, exp);
    end
  endtask

  function automatic bit live(int i);
    return m_key[i][19:18] != 2'b11;
  endfunction

  // one clock: compare everything mid-cycle, then advance the model at the edge
  task automatic cycle();
    bit unm, hit, e_miss, e_inv, e_wp, flt;
    logic [17:0] pfn;
    logic [1:0]  fl;
    logic [31:0] o_index, o_hi, o_lo;
    int sel, found;
    #1;
    unm = (xl_vaddr[31:30] == 2'b11);
    hit = 0; pfn = '0; fl = '0;
    for (int i = 0; i < 32; i++)
      if (live(i) && m_key[i] == xl_vaddr[31:12]) begin
        hit = 1; pfn |= m_pfn[i]; fl |= m_fl[i];
      end
    e_miss = xl_req && !unm && !hit;
    e_inv  = xl_req && !unm && hit && !fl[0];
    e_wp   = xl_req && !unm && hit && fl[0] && xl_store && !fl[1];
    chk("paddr R1 R2", 32'(xl_paddr), unm ? 32'(xl_vaddr[29:0]) : 32'({pfn, xl_vaddr[11:0]}));
    chk("miss R3", 32'(xl_miss), 32'(e_miss));
    chk("invalid R5", 32'(xl_invalid), 32'(e_inv));
    chk("wprot R5", 32'(xl_wprot), 32'(e_wp));
    chk("priv R10", 32'(cmd_priv_fault), 32'(cmd_valid && cmd_user));
    chk("index R9", index_o, m_index);
    chk("entry_hi R4", entry_hi_o, m_hi);
    chk("entry_lo R8", entry_lo_o, m_lo);
    chk("bad_addr R4", bad_addr_o, m_bad);
    @(posedge clk);
    flt = e_miss || e_inv || e_wp;
    o_index = m_index; o_hi = m_hi; o_lo = m_lo;
    if (reg_we) begin
      case (reg_sel)
        2'd0: m_index = reg_wdata & 32'h8000_001F;
        2'd1: m_hi    = reg_wdata & 32'hFFFF_F000;
        2'd2: m_lo    = reg_wdata & 32'h3FFF_F003;
        default: m_bad = reg_wdata;
      endcase
    end
    if (cmd_valid && !cmd_user) begin
      sel = int'(o_index[4:0]);
      case (cmd_op)
        2'd0: begin
          found = -1;
          for (int i = 0; i < 32; i++)
            if (live(i) && m_key[i] == o_hi[31:12]) found = i;
          m_index = (found < 0) ? 32'h8000_0000 : 32'(found);
        end
        2'd1: begin
          m_key[m_ctr] = o_hi[31:12]; m_pfn[m_ctr] = o_lo[29:12]; m_fl[m_ctr] = o_lo[1:0];
        end
        2'd2: begin
          m_hi = {m_key[sel], 12'h000};
          m_lo = {2'b00, m_pfn[sel], 10'h000, m_fl[sel]};
        end
        default: begin
          m_key[sel] = o_hi[31:12]; m_pfn[sel] = o_lo[29:12]; m_fl[sel] = o_lo[1:0];
        end
      endcase
    end
    if (flt) begin
      m_hi  = xl_vaddr & 32'hFFFF_F000;
      m_bad = xl_vaddr;
    end
    m_ctr = (m_ctr == 4) ? 31 : m_ctr - 1;
    @(negedge clk);
  endtask

  task automatic clear_in();
    xl_req = 0; xl_store = 0; xl_vaddr = '0;
    cmd_valid = 0; cmd_user = 0; cmd_op = '0;
    reg_we = 0; reg_sel = '0; reg_wdata = '0;
  endtask

  task automatic wreg(logic [1:0] s, logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    cycle(); clear_in();
  endtask

  task automatic cmd(logic [1:0] op, logic user);
    cmd_valid = 1; cmd_op = op; cmd_user = user;
    cycle(); clear_in();
  endtask

  task automatic xlate(logic [31:0] va, logic st);
    xl_req = 1; xl_vaddr = va; xl_store = st;
    cycle(); clear_in();
  endtask

  task automatic put_idx(int slot, logic [31:0] hi, logic [31:0] lo);
    wreg(2'd1, hi); wreg(2'd2, lo); wreg(2'd0, 32'(slot)); cmd(2'd3, 0);
  endtask

  initial begin : watchdog
    #(5ns * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired (%s)", phase);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_key[i] = 20'hC0000; m_pfn[i] = '0; m_fl[i] = '0;
    end
    m_ctr = 31; m_index = '0; m_hi = '0; m_lo = '0; m_bad = '0;
    repeat (3) @(negedge clk);
    phase = "R12";
    chk("reset index R12", index_o, 32'h0);
    chk("reset hi R12", entry_hi_o, 32'h0);
    chk("reset lo R12", entry_lo_o, 32'h0);
    chk("reset bad R12", bad_addr_o, 32'h0);
    rst_n = 1'b1;
    xlate(32'h0000_0123, 0);          // nothing hits after reset

    phase = "R11";
    wreg(2'd1, 32'h1234_5ABC);
    wreg(2'd2, 32'hFFFF_FFFF);
    wreg(2'd0, 32'hFFFF_FFFF);
    wreg(2'd3, 32'hDEAD_BEEF);
    cycle();

    phase = "R7";
    put_idx(0,  32'h0001_0000, 32'h00AB_C003);
    put_idx(31, 32'h0002_0000, 32'h3FFF_F001);
    put_idx(5,  32'h0003_0000, 32'h0000_0000);
    phase = "R1";
    xlate(32'h0001_0123, 0);
    xlate(32'h0001_0FFF, 1);
    xlate(32'h0002_0ABC, 0);
    phase = "R5";
    xlate(32'h0002_0ABC, 1);          // write-permit clear
    xlate(32'h0003_0004, 0);          // valid clear
    phase = "R3";
    xlate(32'h4000_0ABC, 0);
    xlate(32'h8000_1234, 1);
    phase = "R2";
    xlate(32'hC000_0010, 1);
    xlate(32'hFFFF_FFFF, 0);

    phase = "R9";
    wreg(2'd1, 32'h0002_0000); cmd(2'd0, 0);
    wreg(2'd1, 32'h0009_9000); cmd(2'd0, 0);
    wreg(2'd1, 32'hC000_0000); cmd(2'd0, 0);
    wreg(2'd1, 32'h0001_0000); cmd(2'd0, 0);

    phase = "R8";
    wreg(2'd0, 32'd5);  cmd(2'd2, 0);
    wreg(2'd0, 32'd0);  cmd(2'd2, 0);
    wreg(2'd0, 32'd31); cmd(2'd2, 0);

    phase = "R4";                      // capture beats a same-cycle read
    wreg(2'd0, 32'd0);
    xl_req = 1; xl_vaddr = 32'h5000_0777; cmd_valid = 1; cmd_op = 2'd2;
    cycle(); clear_in();
    cycle();

    phase = "R10";
    wreg(2'd1, 32'h0007_7000); wreg(2'd2, 32'h0001_1003); wreg(2'd0, 32'd1);
    cmd(2'd3, 1);
    cmd(2'd0, 1);
    cmd(2'd2, 1);
    cmd(2'd1, 1);
    xlate(32'h0007_7000, 0);

    phase = "R6";
    for (int k = 0; k < 30; k++) begin
      wreg(2'd1, 32'((32'h400 + k) << 12));
      wreg(2'd2, 32'(((k + 1) << 12) | 1));
      cmd(2'd1, 0);
    end
    for (int k = 0; k < 30; k++) xlate(32'((32'h400 + k) << 12) | 32'h0AA, 0);
    for (int s = 0; s < 32; s++) begin
      wreg(2'd0, 32'(s)); cmd(2'd2, 0);
    end
    xlate(32'h0001_0555, 0);           // slot 0 survives random writes
    repeat (40) cycle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule